// File: doc/BRIEF.md
# Upper-Byte Staging Bridge for a 16-bit Peripheral Bus

This block lets a host with an 8-bit data path carry out 16-bit transfers on a peripheral bus whose data lines are split into a low and a high half. The low half is handled by the host and the bus sequencer. The high half is held in two staging registers owned by this block. One register holds the outgoing high byte and the other holds the incoming one.

For a wide write, the host first stores the high byte in the outgoing register. That store does not start a bus cycle. The host then issues the low-byte write that does start one. While the sequencer marks a write-type cycle as active, the high data lines are driven from the outgoing register, so both halves share the same setup and hold window.

For a wide read, the bus sequencer ends either a data-read strobe or an interrupt-status-read strobe, both active low. On the release of that strobe, the block samples the high data lines into the incoming register. The host later fetches that byte from a dedicated address, and that fetch does not start a bus cycle.

The block also decodes the host accesses that do start bus cycles, and passes each one to the sequencer as a one-cycle request that carries a kind code. A narrow-mode input takes the high half off the bus entirely.

Top module: `bus_widener`

## Requirements
- R1: After reset, `bus_hi_o` is 0, `bus_hi_oe` is 0, `cyc_req` is 0, and a read of host address 5 returns 0.
- R2: A host write (`hst_cs`=1, `hst_we`=1) to address 4 loads `hst_wdata` into the outgoing register. The new value is visible on `bus_hi_o` one cycle later, and the write raises no `cyc_req`.
- R3: With narrow mode off, `bus_hi_oe` equals `wr_cyc` in the same cycle, and `bus_hi_o` always shows the outgoing register.
- R4: The cycle after `rd_data_n` goes from 0 to 1 (with `rd_irpt_n` high), the incoming register holds the value `bus_hi_i` had in the first cycle the strobe was high. Changes of `bus_hi_i` while the strobe is low or steady high are not captured.
- R5: A 0-to-1 transition of `rd_irpt_n` captures `bus_hi_i` into the incoming register in the same way. Capture is triggered by the rise of the AND of both strobes.
- R6: A host read (`hst_we`=0) of address 5 returns the incoming register on `hst_rdata` in the same cycle. It raises no `cyc_req` and leaves the register unchanged. `hst_rdata` is 0 for every other access.
- R7: One cycle after a host access, `cyc_req` pulses for one cycle with a `cyc_kind` code, as follows:
  - write to address 0: kind 1
  - read of address 0: kind 2
  - write to address 1: kind 3
  - write to address 2: kind 4
  - read of address 3: kind 5

  `cyc_lo` carries the write data for write kinds and 0 for read kinds.
- R8: With `mode_narrow`=1, `bus_hi_oe` stays 0 and a read of address 5 returns 8'hFF. The stored register contents are kept for when narrow mode is cleared.
- R9: Accesses not listed in R2, R6 or R7 have no effect: they raise no `cyc_req` and leave the outgoing register unchanged. These are reads of addresses 1, 2 and 4, writes to addresses 3 and 5, and any access to addresses 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_narrow | input | 1 | 1: high bus half unused |
| hst_cs | input | 1 | Host access strobe, one cycle |
| hst_we | input | 1 | Host access is a write |
| hst_addr | input | 3 | Host register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data (incoming high byte) |
| cyc_req | output | 1 | Bus cycle request pulse to the sequencer |
| cyc_kind | output | 3 | Kind of the requested bus cycle |
| cyc_lo | output | 8 | Low byte for the requested cycle |
| wr_cyc | input | 1 | Sequencer: write-type bus cycle active |
| rd_data_n | input | 1 | Data-read strobe, active low |
| rd_irpt_n | input | 1 | Interrupt-status-read strobe, active low |
| bus_hi_i | input | 8 | High data lines as seen on the bus |
| bus_hi_o | output | 8 | High data lines to drive |
| bus_hi_oe | output | 1 | Output enable for the high data lines |

## Verification
The results fall into three timing groups:
- **Same cycle as the stimulus:** `bus_hi_oe` and `hst_rdata` are combinational, so they are due in the cycle the stimulus is applied.
- **One clock later:** bus-cycle requests and the outgoing register appear one clock after the host access.
- **First high cycle of a strobe:** a captured high byte becomes readable in the cycle after the first clock that sees the strobe high.

Every stimulus records its expected values in a queue, each tagged with the cycle in which it is due. A monitor compares them at the falling clock edge of that cycle, so combinational and registered results are each sampled exactly where they settle.

// File: rtl/bus_widener.sv
module bus_widener #(
  parameter int HW = 8,
  parameter int AW = 3,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_narrow,
  input  logic          hst_cs,
  input  logic          hst_we,
  input  logic [AW-1:0] hst_addr,
  input  logic [HW-1:0] hst_wdata,
  output logic [HW-1:0] hst_rdata,
  output logic          cyc_req,
  output logic [KW-1:0] cyc_kind,
  output logic [HW-1:0] cyc_lo,
  input  logic          wr_cyc,
  input  logic          rd_data_n,
  input  logic          rd_irpt_n,
  input  logic [HW-1:0] bus_hi_i,
  output logic [HW-1:0] bus_hi_o,
  output logic          bus_hi_oe
);
  localparam logic [AW-1:0] A_DATA  = AW'(0);
  localparam logic [AW-1:0] A_SEL   = AW'(1);
  localparam logic [AW-1:0] A_MASK  = AW'(2);
  localparam logic [AW-1:0] A_STAT  = AW'(3);
  localparam logic [AW-1:0] A_UPOUT = AW'(4);
  localparam logic [AW-1:0] A_UPIN  = AW'(5);

  localparam logic [KW-1:0] K_NONE = KW'(0);
  localparam logic [KW-1:0] K_WR   = KW'(1);
  localparam logic [KW-1:0] K_RD   = KW'(2);
  localparam logic [KW-1:0] K_SEL  = KW'(3);
  localparam logic [KW-1:0] K_MASK = KW'(4);
  localparam logic [KW-1:0] K_STAT = KW'(5);

  logic [KW-1:0] kind_d;
  logic          start_d;
  logic [HW-1:0] out_q, in_q;
  logic          rd_prev_q;
  logic          rd_all_n, cap;

  always_comb begin
    kind_d = K_NONE;
    case (hst_addr)
      A_DATA: kind_d = hst_we ? K_WR : K_RD;
      A_SEL:  if (hst_we)  kind_d = K_SEL;
      A_MASK: if (hst_we)  kind_d = K_MASK;
      A_STAT: if (!hst_we) kind_d = K_STAT;
      default: kind_d = K_NONE;
    endcase
  end

  assign start_d  = hst_cs && (kind_d != K_NONE);
  assign rd_all_n = rd_data_n & rd_irpt_n;
  assign cap      = rd_all_n & ~rd_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_req   <= 1'b0;
      cyc_kind  <= K_NONE;
      cyc_lo    <= '0;
      out_q     <= '0;
      in_q      <= '0;
      rd_prev_q <= 1'b1;
    end else begin
      cyc_req   <= start_d;
      rd_prev_q <= rd_all_n;
      if (start_d) begin
        cyc_kind <= kind_d;
        cyc_lo   <= hst_we ? hst_wdata : '0;
      end
      if (hst_cs && hst_we && hst_addr == A_UPOUT) out_q <= hst_wdata;
      if (cap) in_q <= bus_hi_i;
    end
  end

  assign bus_hi_o  = out_q;
  assign bus_hi_oe = wr_cyc & ~mode_narrow;
  assign hst_rdata = (hst_cs && !hst_we && hst_addr == A_UPIN)
                     ? (mode_narrow ? '1 : in_q) : '0;
endmodule

module bus_widener_chk #(
  parameter int HW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_narrow,
  input logic          hst_cs,
  input logic          hst_we,
  input logic [AW-1:0] hst_addr,
  input logic [HW-1:0] hst_wdata,
  input logic [HW-1:0] hst_rdata,
  input logic          cyc_req,
  input logic          wr_cyc,
  input logic          rd_data_n,
  input logic          rd_irpt_n,
  input logic [HW-1:0] bus_hi_i,
  input logic [HW-1:0] bus_hi_o,
  input logic          bus_hi_oe,
  input logic [HW-1:0] in_q
);
  p_oe_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cyc |-> !bus_hi_oe);

  p_narrow_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_narrow |-> !bus_hi_oe);

  p_narrow_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_narrow && hst_cs && !hst_we && hst_addr == AW'(5)) |-> (hst_rdata == '1));

  p_upout_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_cs && hst_we && hst_addr == AW'(4)) |=> (bus_hi_o == $past(hst_wdata)));

  p_latch_no_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_cs && hst_addr >= AW'(4)) |=> !cyc_req);

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data_n & rd_irpt_n) |=> (in_q == $past(bus_hi_i)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rd_data_n & rd_irpt_n) |=> $stable(in_q));
endmodule

bind bus_widener bus_widener_chk #(.HW(HW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_narrow(mode_narrow), .hst_cs(hst_cs),
  .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
  .hst_rdata(hst_rdata), .cyc_req(cyc_req), .wr_cyc(wr_cyc),
  .rd_data_n(rd_data_n), .rd_irpt_n(rd_irpt_n), .bus_hi_i(bus_hi_i),
  .bus_hi_o(bus_hi_o), .bus_hi_oe(bus_hi_oe), .in_q(in_q)
);

// File: tb/bus_widener_bench.sv
module bus_widener_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_narrow = 1'b0;
  logic       hst_cs = 1'b0, hst_we = 1'b0;
  logic [2:0] hst_addr = '0;
  logic [7:0] hst_wdata = '0;
  logic [7:0] hst_rdata;
  logic       cyc_req;
  logic [2:0] cyc_kind;
  logic [7:0] cyc_lo;
  logic       wr_cyc = 1'b0, rd_data_n = 1'b1, rd_irpt_n = 1'b1;
  logic [7:0] bus_hi_i = '0;
  logic [7:0] bus_hi_o;
  logic       bus_hi_oe;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    int          sel;
    logic [15:0] val;
    string       rq;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_widener u_bus_widener (
    .clk(clk), .rst_n(rst_n), .mode_narrow(mode_narrow), .hst_cs(hst_cs),
    .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .cyc_req(cyc_req), .cyc_kind(cyc_kind),
    .cyc_lo(cyc_lo), .wr_cyc(wr_cyc), .rd_data_n(rd_data_n),
    .rd_irpt_n(rd_irpt_n), .bus_hi_i(bus_hi_i), .bus_hi_o(bus_hi_o),
    .bus_hi_oe(bus_hi_oe)
  );

  task automatic drive(input logic cs, input logic we, input logic [2:0] a,
                       input logic [7:0] wd, input logic wrc, input logic rdn,
                       input logic irn, input logic [7:0] hi, input logic nar);
    @(posedge clk); #1;
    hst_cs = cs; hst_we = we; hst_addr = a; hst_wdata = wd;
    wr_cyc = wrc; rd_data_n = rdn; rd_irpt_n = irn; bus_hi_i = hi;
    mode_narrow = nar;
  endtask

  task automatic expect_at(input int off, input int sel, input logic [15:0] v,
                           input string rq);
    exp_t e;
    e.due = cyc + off; e.sel = sel; e.val = v; e.rq = rq;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic [15:0] act;
      e = q.pop_front();
      case (e.sel)
        0: act = {4'd0, cyc_req, cyc_kind, cyc_lo};
        1: act = {8'd0, bus_hi_o};
        2: act = {15'd0, bus_hi_oe};
        default: act = {8'd0, hst_rdata};
      endcase
      checks++;
      if (act !== e.val) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h cycle=%0d",
                 e.rq, e.sel, act, e.val, cyc);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state, R6 no request from latch read
    drive(1, 0, 3'd5, 8'h00, 0, 1, 1, 8'h00, 0);
    expect_at(0, 1, 16'h0000, "R1");
    expect_at(0, 2, 16'h0000, "R1");
    expect_at(0, 0, 16'h0000, "R1");
    expect_at(0, 3, 16'h0000, "R1");
    expect_at(1, 0, 16'h0000, "R6");
    // R2 outgoing load
    drive(1, 1, 3'd4, 8'hA5, 0, 1, 1, 8'h00, 0);
    expect_at(1, 1, 16'h00A5, "R2");
    expect_at(1, 0, 16'h0000, "R2");
    // R3 enable follows write cycle
    drive(0, 0, 3'd0, 8'h00, 1, 1, 1, 8'h00, 0);
    expect_at(0, 2, 16'h0001, "R3");
    expect_at(0, 1, 16'h00A5, "R3");
    drive(0, 0, 3'd0, 8'h00, 0, 1, 1, 8'h00, 0);
    expect_at(0, 2, 16'h0000, "R3");
    // R7 request kinds
    drive(1, 1, 3'd0, 8'h3C, 0, 1, 1, 8'h00, 0);
    expect_at(1, 0, {4'd0, 1'b1, 3'd1, 8'h3C}, "R7");
    drive(1, 0, 3'd0, 8'h99, 0, 1, 1, 8'h00, 0);
    expect_at(1, 0, {4'd0, 1'b1, 3'd2, 8'h00}, "R7");
    drive(1, 1, 3'd1, 8'hFE, 0, 1, 1, 8'h00, 0);
    expect_at(1, 0, {4'd0, 1'b1, 3'd3, 8'hFE}, "R7");
    drive(1, 1, 3'd2, 8'h0F, 0, 1, 1, 8'h00, 0);
    expect_at(1, 0, {4'd0, 1'b1, 3'd4, 8'h0F}, "R7");
    drive(1, 0, 3'd3, 8'h00, 0, 1, 1, 8'h00, 0);
    expect_at(1, 0, {4'd0, 1'b1, 3'd5, 8'h00}, "R7");
    // R9 ignored accesses
    drive(1, 1, 3'd3, 8'h11, 0, 1, 1, 8'h00, 0);
    expect_at(1, 0, {4'd0, 1'b0, 3'd5, 8'h00}, "R9");
    drive(1, 0, 3'd1, 8'h00, 0, 1, 1, 8'h00, 0);
    expect_at(1, 0, {4'd0, 1'b0, 3'd5, 8'h00}, "R9");
    drive(1, 1, 3'd7, 8'h22, 0, 1, 1, 8'h00, 0);
    expect_at(1, 0, {4'd0, 1'b0, 3'd5, 8'h00}, "R9");
    expect_at(1, 1, 16'h00A5, "R9");
    drive(1, 1, 3'd5, 8'h33, 0, 1, 1, 8'h00, 0);
    expect_at(1, 1, 16'h00A5, "R9");
    // R4 data-read strobe capture
    drive(0, 0, 3'd0, 8'h00, 0, 0, 1, 8'h11, 0);
    drive(0, 0, 3'd0, 8'h00, 0, 0, 1, 8'h22, 0);
    drive(0, 0, 3'd0, 8'h00, 0, 1, 1, 8'h5A, 0);
    drive(0, 0, 3'd0, 8'h00, 0, 1, 1, 8'h77, 0);
    drive(1, 0, 3'd5, 8'h00, 0, 1, 1, 8'h66, 0);
    expect_at(0, 3, 16'h005A, "R4");
    expect_at(1, 0, {4'd0, 1'b0, 3'd5, 8'h00}, "R6");
    drive(1, 0, 3'd5, 8'h00, 0, 1, 1, 8'h66, 0);
    expect_at(0, 3, 16'h005A, "R6");
    drive(1, 0, 3'd4, 8'h00, 0, 1, 1, 8'h66, 0);
    expect_at(0, 3, 16'h0000, "R6");
    // R5 interrupt-status strobe capture
    drive(0, 0, 3'd0, 8'h00, 0, 1, 0, 8'h44, 0);
    drive(0, 0, 3'd0, 8'h00, 0, 1, 1, 8'hC3, 0);
    drive(0, 0, 3'd0, 8'h00, 0, 1, 1, 8'h12, 0);
    drive(1, 0, 3'd5, 8'h00, 0, 1, 1, 8'h12, 0);
    expect_at(0, 3, 16'h00C3, "R5");
    // R8 narrow mode
    drive(0, 0, 3'd0, 8'h00, 1, 1, 1, 8'h00, 1);
    expect_at(0, 2, 16'h0000, "R8");
    drive(1, 0, 3'd5, 8'h00, 0, 1, 1, 8'h00, 1);
    expect_at(0, 3, 16'h00FF, "R8");
    drive(1, 0, 3'd5, 8'h00, 0, 1, 1, 8'h00, 0);
    expect_at(0, 3, 16'h00C3, "R8");
    drive(0, 0, 3'd0, 8'h00, 1, 1, 1, 8'h00, 0);
    expect_at(0, 1, 16'h00A5, "R8");
    drive(0, 0, 3'd0, 8'h00, 0, 1, 1, 8'h00, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL pending actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule